// File: doc/BRIEF.md
# Serial Character Transmitter with Flow Gating

This block turns bytes from a show-ahead transmit FIFO into asynchronous serial characters on a single output line. Each character is a low start bit, five to eight data bits sent least significant bit first, an optional parity bit and a stop period of one, one and a half or two bit times. Timing comes from an oversample tick supplied by an external baud divider. Every bit lasts sixteen ticks.

Between the end of one stop period and the next start bit, the block can insert a programmed idle gap, counted in whole bit times. When hardware flow control is enabled, the block starts no new character until the clear-to-send input, after synchronization, sits at its programmed active level. A character that is already on the line always runs to its end. A break control forces the line to the spacing level while the serializer keeps its normal timing. An inversion control flips the final line polarity. An idle flag reports when the FIFO is empty and no part of a character remains on the line.

The format settings are captured when a character starts, so a change takes effect at the next character.

Top module: `uart_tx_gate`

## Requirements
- R1: A character is a start bit at 0, then N data bits least significant bit first, then the stop period at 1, where N = 5 + `word_len` (`word_len` 0..3 gives 5..8 bits). Data bits above N are not sent.
- R2: With `par_en`=1 a parity bit follows the data. With `par_stick`=0 it makes the count of ones even (`par_even`=1) or odd (`par_even`=0) over data plus parity. With `par_stick`=1 it is 0 when `par_even`=1 and 1 when `par_even`=0.
- R3: The stop period is 16 ticks when `stop_ext`=0. When `stop_ext`=1 it is 24 ticks for 5-bit words and 32 ticks for 6, 7 or 8-bit words.
- R4: Start and data bits each last 16 ticks, and so does the parity bit when present. With characters waiting and no gap, consecutive start bits are (total character ticks) + 1 clock cycles apart when `tick` is high every cycle.
- R5: With `gap_bits`=G>0, a further 16*G ticks of idle line are inserted after each stop period, before the next start bit.
- R6: With `cts_auto`=1, no character starts and `fifo_pop` stays 0 while the synchronized `cts_in` differs from `cts_act_high`. A character starts once the synchronized `cts_in` equals `cts_act_high`, for either polarity.
- R7: A character already started completes with correct content even if `cts_in` deasserts during it.
- R8: While `brk_en`=1 the line sits at the spacing level (logic 0 before inversion). The character timing continues unchanged, so the character after a break starts on its normal schedule.
- R9: With `inv_out`=1 the whole line, idle level included, is the complement of the normal line.
- R10: `tx_idle` is 1 only when the FIFO is empty and no start, data, parity or stop bit is on the line. It is 0 while characters wait in the FIFO.
- R11: `fifo_pop` pulses for exactly one cycle per character, only while `fifo_empty`=0, in the cycle before the start bit appears.
- R12: After reset, `tx_out`=1, `tx_idle`=1 and `fifo_pop`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversample tick, 16 per bit time |
| fifo_empty | input | 1 | Transmit FIFO holds no byte |
| fifo_data | input | 8 | Byte at the FIFO head (show-ahead) |
| fifo_pop | output | 1 | Removes the head byte from the FIFO |
| word_len | input | 2 | Data bit count minus five |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Constant parity select |
| stop_ext | input | 1 | Extended stop period |
| gap_bits | input | 8 | Idle gap after each character, in bit times |
| cts_auto | input | 1 | Clear-to-send gating enable |
| cts_act_high | input | 1 | Clear-to-send active level is 1 |
| cts_in | input | 1 | Clear-to-send input (asynchronous) |
| brk_en | input | 1 | Force the line to the spacing level |
| inv_out | input | 1 | Invert the line output |
| tx_out | output | 1 | Serial line output |
| tx_idle | output | 1 | FIFO empty and line free |

## Verification
`tx_out` and `tx_idle` each sit one register after the serializer state. The start bit therefore appears on the line one cycle after the `fifo_pop` cycle, and the idle flag rises in the same cycle that the stop period leaves the line. The bench samples on the falling clock edge. It finds each start bit at the first falling edge where the line is low, then reads each bit 8 cycles into its 16-cycle slot. Start-to-start spacing is measured as an exact cycle count equal to the character ticks plus gap ticks plus one. The clear-to-send synchronizer adds two cycles of latency, so gating checks wait hundreds of cycles rather than depending on an exact edge.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_GAP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_in,
  input  logic cts_auto,
  input  logic cts_act_high,
  output logic flow_ok
);
  logic cts_s;

  generate
    if (SYNC_STAGES < 2) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= cts_in;
      end
      assign cts_s = q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= {q[SYNC_STAGES-2:0], cts_in};
      end
      assign cts_s = q[SYNC_STAGES-1];
    end
  endgenerate

  assign flow_ok = !cts_auto || (cts_s == cts_act_high);
endmodule

// File: rtl/uart_tx_gap.sv
module uart_tx_gap #(
  parameter int OVS   = 16,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [GAP_W-1:0] gap_bits,
  output logic             busy
);
  localparam int SUB_W = $clog2(OVS);

  logic [GAP_W-1:0] rem_q;
  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      sub_q <= '0;
    end else if (load) begin
      rem_q <= gap_bits;
      sub_q <= '0;
    end else if (tick && rem_q != '0) begin
      if (sub_q == SUB_W'(OVS-1)) begin
        sub_q <= '0;
        rem_q <= rem_q - 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign busy = (rem_q != '0);
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              flow_ok,
  input  logic              gap_busy,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              stop_ext,
  input  logic [GAP_W-1:0]  gap_bits,
  output logic              fifo_pop,
  output logic              gap_load,
  output logic              line,
  output logic              frame_active
);
  localparam int CNT_W    = $clog2(2*OVS);
  localparam int IDX_W    = $clog2(DATA_W) + 1;
  localparam int MIN_BITS = DATA_W - 3;

  tx_state_e         st;
  logic [CNT_W-1:0]  tcnt;
  logic [IDX_W-1:0]  bidx;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  nbits_q;
  logic              pen_q;
  logic              pbit_q;
  logic [CNT_W-1:0]  stop_last_q;

  logic [IDX_W-1:0]  nbits;
  logic [DATA_W-1:0] mdata;
  logic              pbit;
  logic [CNT_W-1:0]  stop_last;
  logic [CNT_W-1:0]  seg_last;
  logic              seg_end;
  logic              launch_ok;

  // Character format decoded from the live settings, captured at launch
  always_comb begin
    nbits = IDX_W'(MIN_BITS) + IDX_W'(word_len);
    for (int i = 0; i < DATA_W; i++)
      mdata[i] = fifo_data[i] & (IDX_W'(i) < nbits);
    if (par_stick) pbit = ~par_even;
    else           pbit = par_even ? (^mdata) : ~(^mdata);
    if (!stop_ext)            stop_last = CNT_W'(OVS-1);
    else if (word_len == 2'd0) stop_last = CNT_W'(OVS + OVS/2 - 1);
    else                      stop_last = CNT_W'(2*OVS - 1);
  end

  assign seg_last     = (st == ST_STOP) ? stop_last_q : CNT_W'(OVS-1);
  assign seg_end      = tick && (tcnt == seg_last);
  assign frame_active = (st == ST_START) || (st == ST_DATA) ||
                        (st == ST_PAR)   || (st == ST_STOP);
  assign launch_ok    = (st == ST_IDLE) || (st == ST_GAP && !gap_busy);
  assign fifo_pop     = launch_ok && !fifo_empty && flow_ok;
  assign gap_load     = (st == ST_STOP) && seg_end && (gap_bits != '0);

  always_comb begin
    unique case (st)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[0];
      ST_PAR:   line = pbit_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      tcnt        <= '0;
      bidx        <= '0;
      sh_q        <= '0;
      nbits_q     <= '0;
      pen_q       <= 1'b0;
      pbit_q      <= 1'b0;
      stop_last_q <= '0;
    end else begin
      if (frame_active && tick) tcnt <= seg_end ? '0 : tcnt + 1'b1;
      unique case (st)
        ST_IDLE, ST_GAP: begin
          if (fifo_pop) begin
            st          <= ST_START;
            tcnt        <= '0;
            sh_q        <= fifo_data;
            nbits_q     <= nbits;
            pen_q       <= par_en;
            pbit_q      <= pbit;
            stop_last_q <= stop_last;
          end else if (st == ST_GAP && !gap_busy) begin
            st <= ST_IDLE;
          end
        end
        ST_START: if (seg_end) begin
          st   <= ST_DATA;
          bidx <= '0;
        end
        ST_DATA: if (seg_end) begin
          sh_q <= sh_q >> 1;
          bidx <= bidx + 1'b1;
          if (bidx == nbits_q - 1'b1) st <= pen_q ? ST_PAR : ST_STOP;
        end
        ST_PAR:  if (seg_end) st <= ST_STOP;
        ST_STOP: if (seg_end) st <= gap_load ? ST_GAP : ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_gate.sv
module uart_tx_gate #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int GAP_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              stop_ext,
  input  logic [GAP_W-1:0]  gap_bits,
  input  logic              cts_auto,
  input  logic              cts_act_high,
  input  logic              cts_in,
  input  logic              brk_en,
  input  logic              inv_out,
  output logic              tx_out,
  output logic              tx_idle
);
  logic flow_ok;
  logic gap_busy;
  logic gap_load;
  logic line;
  logic frame_active;

  uart_tx_flow #(.SYNC_STAGES(SYNC_STAGES)) i_flow (
    .clk(clk), .rst(rst), .cts_in(cts_in), .cts_auto(cts_auto),
    .cts_act_high(cts_act_high), .flow_ok(flow_ok)
  );

  uart_tx_gap #(.OVS(OVS), .GAP_W(GAP_W)) i_gap (
    .clk(clk), .rst(rst), .tick(tick), .load(gap_load),
    .gap_bits(gap_bits), .busy(gap_busy)
  );

  uart_tx_shift #(.OVS(OVS), .DATA_W(DATA_W), .GAP_W(GAP_W)) i_shift (
    .clk(clk), .rst(rst), .tick(tick), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .flow_ok(flow_ok), .gap_busy(gap_busy),
    .word_len(word_len), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .stop_ext(stop_ext), .gap_bits(gap_bits),
    .fifo_pop(fifo_pop), .gap_load(gap_load), .line(line),
    .frame_active(frame_active)
  );

  // Break and inversion act only on the pin register, never on the shifter
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out  <= 1'b1;
      tx_idle <= 1'b1;
    end else begin
      tx_out  <= (brk_en ? 1'b0 : line) ^ inv_out;
      tx_idle <= fifo_empty && !frame_active;
    end
  end
endmodule

// File: rtl/uart_tx_gate_chk.sv
module uart_tx_gate_chk (
  input logic clk,
  input logic rst,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic cts_auto,
  input logic flow_ok,
  input logic brk_en,
  input logic inv_out,
  input logic tx_out,
  input logic tx_idle
);
  // R11
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  // R11
  pop_single_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);

  // R6
  cts_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop && cts_auto) |-> flow_ok);

  // R8
  break_level_chk: assert property (@(posedge clk) disable iff (rst)
    $past(brk_en) |-> (tx_out == $past(inv_out)));

  // R10
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_idle && !$past(brk_en)) |-> (tx_out == !$past(inv_out)));

  // R10
  pop_clears_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !tx_idle);
endmodule

bind uart_tx_gate uart_tx_gate_chk i_chk (
  .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
  .cts_auto(cts_auto), .flow_ok(flow_ok), .brk_en(brk_en),
  .inv_out(inv_out), .tx_out(tx_out), .tx_idle(tx_idle)
);

// File: tb/test_uart_tx_gate.sv
module test_uart_tx_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       fifo_empty;
  logic [7:0] fifo_data;
  logic       fifo_pop;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, stop_ext = 1'b0;
  logic [7:0] gap_bits = 8'd0;
  logic       cts_auto = 1'b0, cts_act_high = 1'b0, cts_in = 1'b0;
  logic       brk_en = 1'b0, inv_out = 1'b0;
  logic       tx_out, tx_idle;

  int nchk = 0, nfail = 0, cyc = 0, pops = 0, pushes = 0;
  logic [7:0] q [0:15];
  int wr = 0, rd = 0;

  always #5 clk = ~clk;

  assign fifo_empty = (wr == rd);
  assign fifo_data  = q[rd % 16];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_pop) begin
      rd   <= rd + 1;
      pops <= pops + 1;
    end
  end

  uart_tx_gate i_uart_tx_gate (
    .clk(clk), .rst(rst), .tick(tick), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .stop_ext(stop_ext), .gap_bits(gap_bits), .cts_auto(cts_auto),
    .cts_act_high(cts_act_high), .cts_in(cts_in), .brk_en(brk_en),
    .inv_out(inv_out), .tx_out(tx_out), .tx_idle(tx_idle)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #1500000;
    nchk++; nfail++;
    $display("FAIL watchdog: run did not finish, actual=%0d expected=0", cyc);
    summary();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    q[wr % 16] = d;
    wr++;
    pushes++;
  endtask

  function automatic logic exp_par(input logic [7:0] d, input int nb,
                                   input logic ev, input logic stk);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += d[i];
    if (stk) return !ev;
    return ev ? logic'(ones % 2) : logic'(!(ones % 2));
  endfunction

  function automatic int frame_ticks(input int wl, input bit pe, input bit se);
    int st = se ? ((wl == 0) ? 24 : 32) : 16;
    return 16 * (1 + 5 + wl + (pe ? 1 : 0)) + st;
  endfunction

  task automatic wait_start(output int t);
    int n = 0;
    @(negedge clk);
    while ((tx_out ^ inv_out) !== 1'b0 && n < 6000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 6000) chk(0, "start bit timeout", n, 0);
    t = cyc;
  endtask

  // Reads one character, leaves the bench in the middle of the first stop bit
  task automatic rx_frame(input int nb, input bit pe, output logic [7:0] d,
                          output logic pb, output logic sb, output int t0);
    logic s;
    d = '0; pb = 1'b0;
    wait_start(t0);
    repeat (8) @(negedge clk);
    s = tx_out ^ inv_out;
    chk(s == 1'b0, "R1 start bit level", s, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (16) @(negedge clk);
      d[i] = tx_out ^ inv_out;
    end
    if (pe) begin
      repeat (16) @(negedge clk);
      pb = tx_out ^ inv_out;
    end
    repeat (16) @(negedge clk);
    sb = tx_out ^ inv_out;
  endtask

  task automatic set_fmt(input int wl, input bit pe, input bit ev, input bit stk,
                         input bit se, input int gap);
    word_len = 2'(wl); par_en = pe; par_even = ev; par_stick = stk;
    stop_ext = se; gap_bits = 8'(gap);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_out == 1'b1, "R12 tx_out after reset", tx_out, 1);
    chk(tx_idle == 1'b1, "R12 tx_idle after reset", tx_idle, 1);
    chk(fifo_pop == 1'b0, "R12 no pop after reset", fifo_pop, 0);
  endtask

  task automatic t_format(input int wl, input bit pe, input bit ev, input bit stk,
                          input logic [7:0] d);
    logic [7:0] got, expd;
    logic pb, sb, ep;
    int t0, nb;
    nb = 5 + wl;
    set_fmt(wl, pe, ev, stk, 1'b0, 0);
    expd = d & 8'((1 << nb) - 1);
    push(d);
    rx_frame(nb, pe, got, pb, sb, t0);
    chk(got == expd, "R1 data bits lsb first", got, expd);
    if (pe) begin
      ep = exp_par(d, nb, ev, stk);
      chk(pb == ep, "R2 parity bit", pb, ep);
    end
    chk(sb == 1'b1, "R1 stop bit level", sb, 1);
    chk(tx_idle == 1'b0, "R10 idle low during stop bit", tx_idle, 0);
    repeat (12) @(negedge clk);
    chk(tx_idle == 1'b1, "R10 idle high after stop bit left", tx_idle, 1);
    chk(pops == pushes, "R11 one pop per character", pops, pushes);
  endtask

  // Two characters back to back, exact start-to-start spacing
  task automatic t_spacing(input int wl, input bit pe, input bit se, input int gap,
                           input string req);
    int t0, t1, expd;
    set_fmt(wl, pe, 1'b0, 1'b0, se, gap);
    expd = frame_ticks(wl, pe, se) + 16 * gap + 1;
    push(8'h55);
    push(8'h0F);
    wait_start(t0);
    repeat (expd - 12) @(negedge clk);
    wait_start(t1);
    chk((t1 - t0) == expd, req, t1 - t0, expd);
    repeat (expd + 20) @(negedge clk);
    chk(pops == pushes, "R11 pops match pushes after spacing", pops, pushes);
  endtask

  task automatic t_cts();
    logic [7:0] got;
    logic pb, sb;
    int t0, p0;
    bit moved;
    set_fmt(3, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    // Active low level, held deasserted
    cts_auto = 1'b1; cts_act_high = 1'b0; cts_in = 1'b1;
    repeat (4) @(negedge clk);
    p0 = pops;
    push(8'hC3);
    moved = 0;
    repeat (300) begin
      @(negedge clk);
      if (tx_out !== 1'b1) moved = 1;
    end
    chk(!moved, "R6 line stays idle while cts deasserted", moved, 0);
    chk(pops == p0, "R6 no pop while cts deasserted", pops, p0);
    chk(tx_idle == 1'b0, "R10 idle low with byte waiting", tx_idle, 0);
    cts_in = 1'b0;
    rx_frame(8, 1'b0, got, pb, sb, t0);
    chk(got == 8'hC3, "R6 character sent once cts asserted low", got, 8'hC3);
    // Deassert in the middle of a character
    push(8'h96);
    push(8'h3C);
    wait_start(t0);
    repeat (40) @(negedge clk);
    cts_in = 1'b1;
    repeat (150) @(negedge clk);
    chk(tx_out == 1'b1, "R7 stop level after interrupted cts", tx_out, 1);
    p0 = pops;
    repeat (300) @(negedge clk);
    chk(pops == p0, "R6 second byte held after cts dropped", pops, p0);
    chk(p0 == pushes - 1, "R7 first byte completed and popped", p0, pushes - 1);
    // Active high level
    cts_act_high = 1'b1;
    cts_in = 1'b1;
    rx_frame(8, 1'b0, got, pb, sb, t0);
    chk(got == 8'h3C, "R6 character sent with cts active high", got, 8'h3C);
    repeat (20) @(negedge clk);
    cts_auto = 1'b0;
  endtask

  task automatic t_mid_frame_content();
    logic [7:0] got;
    logic pb, sb;
    int t0;
    cts_auto = 1'b1; cts_act_high = 1'b1; cts_in = 1'b1;
    repeat (4) @(negedge clk);
    push(8'hA6);
    fork
      rx_frame(8, 1'b0, got, pb, sb, t0);
      begin
        repeat (60) @(negedge clk);
        cts_in = 1'b0;
      end
    join
    chk(got == 8'hA6, "R7 content intact after cts dropped mid character", got, 8'hA6);
    chk(sb == 1'b1, "R7 stop bit sent after cts dropped", sb, 1);
    repeat (20) @(negedge clk);
    cts_auto = 1'b0;
  endtask

  task automatic t_break();
    logic [7:0] got;
    logic pb, sb;
    int t0, t1;
    bit bad;
    set_fmt(3, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    push(8'hFF);
    push(8'h5A);
    wait_start(t0);
    brk_en = 1'b1;
    bad = 0;
    for (int i = 0; i < 9; i++) begin
      repeat (16) @(negedge clk);
      if (tx_out !== 1'b0) bad = 1;
    end
    chk(!bad, "R8 line forced low during break", bad, 0);
    brk_en = 1'b0;
    rx_frame(8, 1'b0, got, pb, sb, t1);
    chk((t1 - t0) == 161, "R8 timing unchanged by break", t1 - t0, 161);
    chk(got == 8'h5A, "R8 next character intact after break", got, 8'h5A);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_invert();
    logic [7:0] got;
    logic pb, sb;
    int t0;
    set_fmt(1, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    inv_out = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_out == 1'b0, "R9 inverted idle level", tx_out, 0);
    push(8'h2D);
    rx_frame(6, 1'b1, got, pb, sb, t0);
    chk(got == 8'h2D, "R9 inverted data bits", got, 8'h2D);
    chk(pb == exp_par(8'h2D, 6, 1'b1, 1'b0), "R9 inverted parity", pb,
        exp_par(8'h2D, 6, 1'b1, 1'b0));
    chk(sb == 1'b1, "R9 inverted stop bit", sb, 1);
    repeat (20) @(negedge clk);
    inv_out = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_format(3, 1'b0, 1'b0, 1'b0, 8'hA5);
    t_format(0, 1'b1, 1'b1, 1'b0, 8'hF3);
    t_format(2, 1'b1, 1'b0, 1'b0, 8'hDA);
    t_format(1, 1'b1, 1'b1, 1'b1, 8'h2C);
    t_format(3, 1'b1, 1'b0, 1'b1, 8'h81);
    t_spacing(3, 1'b0, 1'b0, 0, "R4 spacing 8N1");
    t_spacing(0, 1'b0, 1'b1, 0, "R3 one and a half stop on 5-bit word");
    t_spacing(2, 1'b1, 1'b1, 0, "R3 two stop bits on 7-bit word");
    t_spacing(3, 1'b0, 1'b0, 3, "R5 gap of three bit times");
    t_spacing(0, 1'b0, 1'b0, 1, "R5 gap of one bit time");
    t_cts();
    t_mid_frame_content();
    t_break();
    t_invert();
    chk(pops == pushes, "R11 total pops", pops, pushes);
    summary();
  end
endmodule